// File: doc/BRIEF.md
# Frame Buffer Scan Address Generator

This block turns the line and pixel strobes of a panel timing generator into the memory read addresses that fetch a 16-bit-per-pixel image in raster order. The image sits in one of several equally shaped buffers in memory. The panel shows a panel-sized window into a frame that may be larger than the panel. The window position is set by a per-band X/Y offset, so moving the offset pans the image. The horizontal and vertical scan directions can each be reversed on their own.

The screen can be divided into horizontal bands. Each band starts at a configured screen row and reads from its own source buffer at its own offset, so one area can hold a fixed control panel while another pans over a large picture. Band 0 always starts at row 0 and reads the buffer named by the active-buffer register, which gives double buffering. The host renders into one buffer while the other is displayed, then switches the active-buffer register.

All display configuration is captured at the start of vertical blanking, so no frame mixes two sources. Buffer base addresses are written through a small write port. Odd values are refused and raise a sticky error flag.

Top module: `fb_scan_addr`

## Requirements
- R1: For each cycle with `pix_strobe` high, `rd_valid` is high in the next cycle and `rd_addr` equals base + (row × frame width + column) × 2, truncated to ADDR_W bits. In any cycle not preceded by a `pix_strobe`, `rd_valid` is low.
- R2: Column = screen column + band X offset. Row = screen row − band start row + band Y offset. Band 0 has a start row of 0.
- R3: An X offset above (frame width − panel width) is clipped to that value, and a Y offset above (frame height − panel height) is clipped to that value. Either limit is 0 when the frame is not larger than the panel on that axis.
- R4: With `mirror_h` = 1, pixel p of a line maps to screen column (panel width − 1 − p). Otherwise it maps to column p.
- R5: With `mirror_v` = 1, line n of a frame maps to screen row (panel height − 1 − n). Otherwise it maps to row n. Both mirrors may be active together.
- R6: The band used for a screen row is the highest index k, with 1 ≤ k < `band_cnt`, whose start row is ≤ that row. If no such k exists, band 0 is used. Band 0 reads the buffer named by `act_buf`. Band k ≥ 1 reads `band_buf[k]`. Start rows are expected to ascend with k.
- R7: A write with `cfg_we` = 1 stores `cfg_data` as the base of buffer `cfg_idx` only when bit 0 of the data is 0. An odd value leaves the base unchanged and sets `base_err` in the next cycle. `base_err` then stays high until reset.
- R8: `act_buf`, panel and frame sizes, mirror bits, `band_cnt` and all band tables are sampled only in a cycle with `vblank_start` high. Changes at any other time have no effect on addresses until the next such cycle.
- R9: The first `line_start` after `vblank_start` (or after reset) selects line 0. Each later `line_start` advances the line by one and returns the pixel index to 0. Each `pix_strobe` advances the pixel index by one after its address is formed.
- R10: Reset clears `rd_valid`, `rd_addr`, `base_err` and all buffer bases to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_start | input | 1 | Start of vertical blanking; captures configuration |
| line_start | input | 1 | Start of an active line |
| pix_strobe | input | 1 | Request the address of the next pixel |
| cfg_we | input | 1 | Base address write enable |
| cfg_idx | input | IDX_W | Buffer index for the base write |
| cfg_data | input | ADDR_W | Base address value (must be even) |
| act_buf | input | IDX_W | Buffer shown by band 0 |
| frame_w | input | COORD_W | Frame width in pixels |
| frame_h | input | COORD_W | Frame height in lines |
| panel_w | input | COORD_W | Panel active width in pixels |
| panel_h | input | COORD_W | Panel active height in lines |
| mirror_h | input | 1 | Reverse pixel order within a line |
| mirror_v | input | 1 | Reverse line order within a frame |
| band_cnt | input | CNT_W | Number of bands in use (0 treated as 1) |
| band_start | input | NBAND×COORD_W | Screen start row per band (entry 0 unused) |
| band_buf | input | NBAND×IDX_W | Source buffer per band (entry 0 unused) |
| band_xoff | input | NBAND×COORD_W | X pan offset per band |
| band_yoff | input | NBAND×COORD_W | Y pan offset per band |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_valid | output | 1 | `rd_addr` holds a new address |
| base_err | output | 1 | Sticky flag for a refused odd base write |

## Verification
A wrong captured configuration, such as a stale buffer select, offset or mirror bit, is visible from the first address of the next frame. It shifts every address in the affected band by a constant or reverses their order. A line or pixel counter that slips shows up at the next address, as a jump of one frame-width stride or one pixel pair. A wrong band choice appears on the first row past a band boundary as a change of base. A mishandled base write is seen on `base_err` one cycle later, or as a wrong base in the next frame that reads that buffer.

// File: rtl/fbsa_pkg.sv
package fbsa_pkg;

  // Reverse an index within a span when enabled.
  function automatic logic [31:0] fbsa_mirror(input logic [31:0] idx,
                                              input logic [31:0] span,
                                              input logic        en);
    return en ? (span - 32'd1 - idx) : idx;
  endfunction

  // Largest offset that keeps the window inside the frame on one axis.
  function automatic logic [31:0] fbsa_clip_offset(input logic [31:0] off,
                                                   input logic [31:0] frame_len,
                                                   input logic [31:0] panel_len);
    logic [31:0] lim;
    lim = (frame_len > panel_len) ? (frame_len - panel_len) : 32'd0;
    return (off > lim) ? lim : off;
  endfunction

  // Byte address of a 16-bit pixel.
  function automatic logic [31:0] fbsa_pixel_addr(input logic [31:0] base,
                                                  input logic [31:0] row,
                                                  input logic [31:0] col,
                                                  input logic [31:0] stride);
    return base + ((row * stride + col) << 1);
  endfunction

endpackage

// File: rtl/fbsa_base_regs.sv
module fbsa_base_regs #(
  parameter int NBUF   = 4,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  logic [ADDR_W-1:0]            data,
  output logic [NBUF-1:0][ADDR_W-1:0]  bases,
  output logic                         err
);

  logic odd_wr;
  assign odd_wr = we & data[0];

  for (genvar g = 0; g < NBUF; g++) begin : g_base
    logic hit;
    assign hit = we && !data[0] && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bases[g] <= '0;
      else if (hit) bases[g] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err <= 1'b0;
    else if (odd_wr) err <= 1'b1;
  end

endmodule

// File: rtl/fbsa_shadow.sv
module fbsa_shadow
  import fbsa_pkg::*;
#(
  parameter int NBAND   = 4,
  parameter int COORD_W = 12,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           capture,
  input  logic [IDX_W-1:0]               act_buf,
  input  logic [COORD_W-1:0]             frame_w,
  input  logic [COORD_W-1:0]             frame_h,
  input  logic [COORD_W-1:0]             panel_w,
  input  logic [COORD_W-1:0]             panel_h,
  input  logic                           mirror_h,
  input  logic                           mirror_v,
  input  logic [CNT_W-1:0]               band_cnt,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_start,
  input  logic [NBAND-1:0][IDX_W-1:0]    band_buf,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_xoff,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_yoff,
  output logic [IDX_W-1:0]               sh_act,
  output logic [COORD_W-1:0]             sh_fw,
  output logic [COORD_W-1:0]             sh_pw,
  output logic [COORD_W-1:0]             sh_ph,
  output logic                           sh_mh,
  output logic                           sh_mv,
  output logic [CNT_W-1:0]               sh_cnt,
  output logic [NBAND-1:0][COORD_W-1:0]  sh_start,
  output logic [NBAND-1:0][IDX_W-1:0]    sh_buf,
  output logic [NBAND-1:0][COORD_W-1:0]  sh_xoff,
  output logic [NBAND-1:0][COORD_W-1:0]  sh_yoff
);

  logic [NBAND-1:0][COORD_W-1:0] xo_clip;
  logic [NBAND-1:0][COORD_W-1:0] yo_clip;

  for (genvar g = 0; g < NBAND; g++) begin : g_clip
    assign xo_clip[g] = COORD_W'(fbsa_clip_offset(32'(band_xoff[g]), 32'(frame_w), 32'(panel_w)));
    assign yo_clip[g] = COORD_W'(fbsa_clip_offset(32'(band_yoff[g]), 32'(frame_h), 32'(panel_h)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_act   <= '0;
      sh_fw    <= '0;
      sh_pw    <= '0;
      sh_ph    <= '0;
      sh_mh    <= 1'b0;
      sh_mv    <= 1'b0;
      sh_cnt   <= '0;
      sh_start <= '0;
      sh_buf   <= '0;
      sh_xoff  <= '0;
      sh_yoff  <= '0;
    end else if (capture) begin
      sh_act   <= act_buf;
      sh_fw    <= frame_w;
      sh_pw    <= panel_w;
      sh_ph    <= panel_h;
      sh_mh    <= mirror_h;
      sh_mv    <= mirror_v;
      sh_cnt   <= band_cnt;
      sh_start <= band_start;
      sh_buf   <= band_buf;
      sh_xoff  <= xo_clip;
      sh_yoff  <= yo_clip;
    end
  end

endmodule

// File: rtl/fbsa_scan_ctr.sv
module fbsa_scan_ctr #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_evt,
  input  logic               line_evt,
  input  logic               pix_evt,
  output logic [COORD_W-1:0] line_idx,
  output logic [COORD_W-1:0] pix_idx
);

  logic first_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx      <= '0;
      pix_idx       <= '0;
      first_pending <= 1'b1;
    end else if (frame_evt) begin
      pix_idx       <= '0;
      first_pending <= 1'b1;
    end else if (line_evt) begin
      pix_idx       <= '0;
      first_pending <= 1'b0;
      line_idx      <= first_pending ? '0 : line_idx + 1'b1;
    end else if (pix_evt) begin
      pix_idx <= pix_idx + 1'b1;
    end
  end

endmodule

// File: rtl/fbsa_band_sel.sv
module fbsa_band_sel #(
  parameter int NBAND   = 4,
  parameter int COORD_W = 12,
  parameter int CNT_W   = 3,
  parameter int BAND_W  = 2
) (
  input  logic [COORD_W-1:0]             row,
  input  logic [CNT_W-1:0]               cnt,
  input  logic [NBAND-1:0][COORD_W-1:0]  starts,
  output logic [BAND_W-1:0]              sel
);

  always_comb begin
    sel = '0;
    for (int k = 1; k < NBAND; k++) begin
      if ((k < int'(cnt)) && (starts[k] <= row)) sel = BAND_W'(k);
    end
  end

endmodule

// File: rtl/fb_scan_addr.sv
module fb_scan_addr
  import fbsa_pkg::*;
#(
  parameter  int NBUF    = 4,
  parameter  int NBAND   = 4,
  parameter  int COORD_W = 12,
  parameter  int ADDR_W  = 24,
  localparam int IDX_W   = $clog2(NBUF),
  localparam int BAND_W  = $clog2(NBAND),
  localparam int CNT_W   = $clog2(NBAND + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vblank_start,
  input  logic                           line_start,
  input  logic                           pix_strobe,
  input  logic                           cfg_we,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [ADDR_W-1:0]              cfg_data,
  input  logic [IDX_W-1:0]               act_buf,
  input  logic [COORD_W-1:0]             frame_w,
  input  logic [COORD_W-1:0]             frame_h,
  input  logic [COORD_W-1:0]             panel_w,
  input  logic [COORD_W-1:0]             panel_h,
  input  logic                           mirror_h,
  input  logic                           mirror_v,
  input  logic [CNT_W-1:0]               band_cnt,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_start,
  input  logic [NBAND-1:0][IDX_W-1:0]    band_buf,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_xoff,
  input  logic [NBAND-1:0][COORD_W-1:0]  band_yoff,
  output logic [ADDR_W-1:0]              rd_addr,
  output logic                           rd_valid,
  output logic                           base_err
);

  // Stored buffer bases
  logic [NBUF-1:0][ADDR_W-1:0] bases;

  fbsa_base_regs #(.NBUF(NBUF), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bases (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .data  (cfg_data),
    .bases (bases),
    .err   (base_err)
  );

  // Frame-stable configuration
  logic [IDX_W-1:0]               sh_act_buf;
  logic [COORD_W-1:0]             sh_fw, sh_pw, sh_ph;
  logic                           sh_mir_h, sh_mir_v;
  logic [CNT_W-1:0]               sh_cnt;
  logic [NBAND-1:0][COORD_W-1:0]  sh_start, sh_xoff, sh_yoff;
  logic [NBAND-1:0][IDX_W-1:0]    sh_buf;

  fbsa_shadow #(.NBAND(NBAND), .COORD_W(COORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (vblank_start),
    .act_buf    (act_buf),
    .frame_w    (frame_w),
    .frame_h    (frame_h),
    .panel_w    (panel_w),
    .panel_h    (panel_h),
    .mirror_h   (mirror_h),
    .mirror_v   (mirror_v),
    .band_cnt   (band_cnt),
    .band_start (band_start),
    .band_buf   (band_buf),
    .band_xoff  (band_xoff),
    .band_yoff  (band_yoff),
    .sh_act     (sh_act_buf),
    .sh_fw      (sh_fw),
    .sh_pw      (sh_pw),
    .sh_ph      (sh_ph),
    .sh_mh      (sh_mir_h),
    .sh_mv      (sh_mir_v),
    .sh_cnt     (sh_cnt),
    .sh_start   (sh_start),
    .sh_buf     (sh_buf),
    .sh_xoff    (sh_xoff),
    .sh_yoff    (sh_yoff)
  );

  // Raster position
  logic [COORD_W-1:0] line_idx, pix_idx;

  fbsa_scan_ctr #(.COORD_W(COORD_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_evt (vblank_start),
    .line_evt  (line_start),
    .pix_evt   (pix_strobe),
    .line_idx  (line_idx),
    .pix_idx   (pix_idx)
  );

  // Screen coordinates after mirroring
  logic [COORD_W-1:0] scr_row, scr_col;
  assign scr_row = COORD_W'(fbsa_mirror(32'(line_idx), 32'(sh_ph), sh_mir_v));
  assign scr_col = COORD_W'(fbsa_mirror(32'(pix_idx),  32'(sh_pw), sh_mir_h));

  // Band choice
  logic [BAND_W-1:0] band_sel;

  fbsa_band_sel #(.NBAND(NBAND), .COORD_W(COORD_W), .CNT_W(CNT_W), .BAND_W(BAND_W)) u_band (
    .row    (scr_row),
    .cnt    (sh_cnt),
    .starts (sh_start),
    .sel    (band_sel)
  );

  // Source coordinates and address
  logic [IDX_W-1:0]   src_buf;
  logic [COORD_W-1:0] band_top;
  logic [31:0]        src_row, src_col;
  logic [ADDR_W-1:0]  next_addr;

  assign src_buf   = (band_sel == '0) ? sh_act_buf : sh_buf[band_sel];
  assign band_top  = (band_sel == '0) ? '0 : sh_start[band_sel];
  assign src_row   = 32'(scr_row) - 32'(band_top) + 32'(sh_yoff[band_sel]);
  assign src_col   = 32'(scr_col) + 32'(sh_xoff[band_sel]);
  assign next_addr = ADDR_W'(fbsa_pixel_addr(32'(bases[src_buf]), src_row, src_col, 32'(sh_fw)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_valid <= pix_strobe;
      if (pix_strobe) rd_addr <= next_addr;
    end
  end

endmodule

// File: rtl/fbsa_checker.sv
module fbsa_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_strobe,
  input logic             vblank_start,
  input logic             cfg_we,
  input logic             cfg_lsb,
  input logic             rd_valid,
  input logic             rd_lsb,
  input logic             base_err,
  input logic [IDX_W-1:0] sh_act,
  input logic             sh_mh,
  input logic             sh_mv
);

  assert_valid_follows_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> rd_valid);

  assert_no_valid_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_strobe |=> !rd_valid);

  assert_even_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_lsb);

  assert_odd_write_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_lsb) |=> base_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    base_err |=> base_err);

  assert_act_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable(sh_act));

  assert_mirror_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable({sh_mh, sh_mv}));

endmodule

bind fb_scan_addr fbsa_checker #(.IDX_W(IDX_W)) u_fbsa_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_strobe   (pix_strobe),
  .vblank_start (vblank_start),
  .cfg_we       (cfg_we),
  .cfg_lsb      (cfg_data[0]),
  .rd_valid     (rd_valid),
  .rd_lsb       (rd_addr[0]),
  .base_err     (base_err),
  .sh_act       (sh_act_buf),
  .sh_mh        (sh_mir_h),
  .sh_mv        (sh_mir_v)
);

// File: tb/fb_scan_addr_bench.sv
module fb_scan_addr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 4, NBAND = 4, COORD_W = 12, ADDR_W = 24;
  localparam int IDX_W = 2, CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vblank_start = 0, line_start = 0, pix_strobe = 0, cfg_we = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [ADDR_W-1:0] cfg_data = '0;
  logic [IDX_W-1:0] act_buf = '0;
  logic [COORD_W-1:0] frame_w = '0, frame_h = '0, panel_w = '0, panel_h = '0;
  logic mirror_h = 0, mirror_v = 0;
  logic [CNT_W-1:0] band_cnt = '0;
  logic [NBAND-1:0][COORD_W-1:0] band_start = '0, band_xoff = '0, band_yoff = '0;
  logic [NBAND-1:0][IDX_W-1:0] band_buf = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic rd_valid, base_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scan_addr u_fb_scan_addr (
    .clk(clk), .rst_n(rst_n), .vblank_start(vblank_start), .line_start(line_start),
    .pix_strobe(pix_strobe), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .act_buf(act_buf), .frame_w(frame_w), .frame_h(frame_h), .panel_w(panel_w),
    .panel_h(panel_h), .mirror_h(mirror_h), .mirror_v(mirror_v), .band_cnt(band_cnt),
    .band_start(band_start), .band_buf(band_buf), .band_xoff(band_xoff),
    .band_yoff(band_yoff), .rd_addr(rd_addr), .rd_valid(rd_valid), .base_err(base_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model state
  int m_base[NBUF];
  bit m_err;
  int s_act, s_fw, s_pw, s_ph, s_mh, s_mv, s_cnt;
  int s_start[NBAND], s_buf[NBAND], s_xo[NBAND], s_yo[NBAND];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clip(input int off, input int flen, input int plen);
    int room;
    room = flen - plen;
    if (room < 0) room = 0;
    return (off < room) ? off : room;
  endfunction

  function automatic int expect_addr(input int ln, input int px);
    int row, col, b, buf_id, top, a;
    row = s_mv ? (s_ph - 1 - ln) : ln;
    col = s_mh ? (s_pw - 1 - px) : px;
    b = 0;
    for (int k = NBAND - 1; k >= 1; k--)
      if (b == 0 && k < s_cnt && s_start[k] <= row) b = k;
    buf_id = (b == 0) ? s_act : s_buf[b];
    top = (b == 0) ? 0 : s_start[b];
    a = m_base[buf_id] + 2 * ((row - top + s_yo[b]) * s_fw + col + s_xo[b]);
    return a & 32'h00FF_FFFF;
  endfunction

  task automatic write_base(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_data = ADDR_W'(val);
    @(negedge clk);
    cfg_we = 0;
    if (val % 2 == 0) m_base[idx] = val; else m_err = 1;
    check(base_err == m_err, "R7 base_err", int'(base_err), int'(m_err));
  endtask

  task automatic vblank();
    @(negedge clk);
    vblank_start = 1;
    s_act = act_buf; s_fw = frame_w; s_pw = panel_w; s_ph = panel_h;
    s_mh = mirror_h; s_mv = mirror_v; s_cnt = band_cnt;
    for (int k = 0; k < NBAND; k++) begin
      s_start[k] = band_start[k]; s_buf[k] = band_buf[k];
      s_xo[k] = clip(band_xoff[k], frame_w, panel_w);
      s_yo[k] = clip(band_yoff[k], frame_h, panel_h);
    end
    @(negedge clk);
    vblank_start = 0;
  endtask

  task automatic new_line();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic pixel(input string req, input int ln, input int px);
    int e;
    @(negedge clk); pix_strobe = 1;
    @(negedge clk); pix_strobe = 0;
    e = expect_addr(ln, px);
    check(rd_valid === 1'b1, "R1 valid", int'(rd_valid), 1);
    check(int'(rd_addr) == e, req, int'(rd_addr), e);
  endtask

  task automatic rand_cfg();
    int s;
    panel_w = COORD_W'(3 + $urandom % 6);
    panel_h = COORD_W'(2 + $urandom % 5);
    frame_w = panel_w + COORD_W'($urandom % 7);
    frame_h = panel_h + COORD_W'($urandom % 5);
    act_buf = IDX_W'($urandom % 4);
    mirror_h = 1'($urandom % 2);
    mirror_v = 1'($urandom % 2);
    band_cnt = CNT_W'($urandom % 5);
    s = 0;
    for (int k = 0; k < NBAND; k++) begin
      s = s + ($urandom % 3);
      band_start[k] = COORD_W'(s);
      band_buf[k] = IDX_W'($urandom % 4);
      band_xoff[k] = COORD_W'($urandom % 12);
      band_yoff[k] = COORD_W'($urandom % 8);
    end
  endtask

  task automatic plain_cfg(input int pw, input int ph, input int fw, input int fh);
    panel_w = COORD_W'(pw); panel_h = COORD_W'(ph);
    frame_w = COORD_W'(fw); frame_h = COORD_W'(fh);
    act_buf = '0; mirror_h = 0; mirror_v = 0; band_cnt = CNT_W'(1);
    band_start = '0; band_buf = '0; band_xoff = '0; band_yoff = '0;
  endtask

  // Scan a whole frame; optionally disturb the live configuration mid-frame (R8)
  task automatic scan_frame(input string req, input bit disturb);
    for (int l = 0; l < s_ph; l++) begin
      new_line();
      if (disturb && l == 1) rand_cfg();
      for (int p = 0; p < s_pw; p++) pixel(req, l, p);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NBUF; i++) m_base[i] = 0;
    m_err = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rd_valid == 1'b0, "R10 rd_valid", int'(rd_valid), 0);
    check(rd_addr == '0, "R10 rd_addr", int'(rd_addr), 0);
    check(base_err == 1'b0, "R10 base_err", int'(base_err), 0);
    rst_n = 1;
    @(negedge clk);
    // R10: bases are zero after reset (scan with no writes)
    plain_cfg(3, 2, 3, 2);
    vblank();
    scan_frame("R10 zero base", 0);

    for (int i = 0; i < NBUF; i++) write_base(i, (i + 1) * 32'h1000);

    // R7: odd write refused, base unchanged
    write_base(1, 32'h2001);
    check(base_err == 1'b1, "R7 odd flagged", int'(base_err), 1);
    plain_cfg(4, 3, 8, 5);
    act_buf = 2'd1;
    vblank();
    new_line();
    pixel("R7 base kept", 0, 0);
    check(int'(rd_addr) == 32'h2000, "R7 base kept direct", int'(rd_addr), 32'h2000);
    write_base(1, 32'h2100);
    check(base_err == 1'b1, "R7 sticky", int'(base_err), 1);

    // R9: line numbering and pixel reset, then R1 on a plain frame
    plain_cfg(4, 3, 8, 5);
    vblank();
    new_line(); pixel("R9 line0", 0, 0); pixel("R9 line0", 0, 1);
    new_line(); pixel("R9 line1 px0", 1, 0);
    check(int'(rd_addr) == 32'h1000 + 2 * 8, "R9 stride", int'(rd_addr), 32'h1010);
    vblank();
    scan_frame("R1 plain", 0);

    // R4/R5: both mirrors, first pixel is bottom-right
    plain_cfg(4, 3, 8, 5);
    mirror_h = 1; mirror_v = 1;
    vblank();
    new_line(); pixel("R5 both mirrors", 0, 0);
    check(int'(rd_addr) == 32'h1000 + 2 * (2 * 8 + 3), "R4 corner", int'(rd_addr), 32'h1026);
    vblank(); scan_frame("R4 mirror", 0);
    mirror_h = 0; vblank(); scan_frame("R5 vmirror", 0);

    // R2/R3: panning and clipping
    plain_cfg(4, 3, 8, 5);
    band_xoff[0] = 12'd2; band_yoff[0] = 12'd1;
    vblank(); scan_frame("R2 pan", 0);
    band_xoff[0] = 12'd100; band_yoff[0] = 12'd9;
    vblank();
    new_line(); pixel("R3 clip", 0, 0);
    check(int'(rd_addr) == 32'h1000 + 2 * (2 * 8 + 4), "R3 clip direct", int'(rd_addr), 32'h1028);
    new_line(); new_line();
    for (int p = 0; p < 4; p++) pixel("R3 clip", 2, p);

    // R6: two bands, second from buffer 2 starting at row 2
    plain_cfg(4, 4, 4, 4);
    band_cnt = 3'd2; band_start[1] = 12'd2; band_buf[1] = 2'd2;
    vblank();
    new_line(); new_line(); pixel("R6 band0", 1, 0);
    check(int'(rd_addr) == 32'h1000 + 8, "R6 band0 direct", int'(rd_addr), 32'h1008);
    new_line(); pixel("R6 band1", 2, 0);
    check(int'(rd_addr) == 32'h3000, "R6 band1 direct", int'(rd_addr), 32'h3000);
    band_cnt = 3'd1; vblank(); scan_frame("R6 count limits bands", 0);

    // R8: live changes mid-frame ignored
    plain_cfg(5, 4, 9, 6);
    band_xoff[0] = 12'd3;
    vblank();
    scan_frame("R8 mid-frame change", 1);

    // Random frames
    for (int f = 0; f < 30; f++) begin
      rand_cfg();
      vblank();
      scan_frame((f % 2) ? "R6 random" : "R8 random", (f % 3) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule